// File: doc/BRIEF.md
# Split-Word Counter Coherent Reader

This block builds one consistent 64-bit reading from a free-running 64-bit counter that can only be reached through a 32-bit read port. A start pulse launches an attempt of three narrow reads in a fixed order: upper half, lower half, upper half again. The lower half is sampled only once. The block then decides which upper sample belongs with that lower sample, writes the joined word to a result register and pulses a done strobe.

The policy input is sampled when a start is accepted. It selects one of two ways of handling a carry. In carry-resolve policy, a disagreement between the two upper samples is settled by the top bit of the lower sample. This is correct only while the gap between the first and last read of an attempt stays well under half the wrap period of the lower half. In retry policy, a disagreement throws the attempt away and runs all three reads again. If the upper samples still disagree after `RETRY_MAX` retries, the block stops with an error flag and gives no result.

The read port uses a plain request/valid handshake. The block holds `rd_req` and the half select until `rd_valid` comes back, and it captures `rd_data` in the cycle where `rd_valid` is high. A response may arrive in the same cycle as the request or any number of cycles later.

Top module: `split_counter_reader`

## Requirements
- R1: Each attempt issues exactly three reads, in the order upper, lower, upper, with `rd_sel` = 1 selecting the upper half and `rd_sel` = 0 selecting the lower half.
- R2: Once asserted, `rd_req` and `rd_sel` stay unchanged until a cycle with `rd_valid` high. The data of a read is the `rd_data` value present in that cycle.
- R3: When the two upper samples are equal, the result is {upper sample, lower sample}, under either policy.
- R4: In carry-resolve policy (`retry_mode` = 0), when the upper samples differ and bit 31 of the lower sample is 1, the result is {first upper sample, lower sample}.
- R5: In carry-resolve policy, when the upper samples differ and bit 31 of the lower sample is 0, the result is {second upper sample, lower sample}.
- R6: The lower half is read once per attempt, and the result always carries that single lower sample.
- R7: In retry policy (`retry_mode` = 1), differing upper samples discard the attempt and start a fresh upper, lower, upper sequence. A result is produced only from an attempt whose two upper samples match.
- R8: In retry policy, if the attempt after `RETRY_MAX` retries (default 8, so 9 attempts in all) still disagrees, `error` rises and stays high, no done pulse is given and `busy` drops. The next accepted start clears `error`.
- R9: A start is accepted only while `busy` is low. A start pulse while `busy` is high has no effect on the read sequence or the result.
- R10: `done` is high for exactly one cycle, two cycles after the valid cycle of the third read of the accepted attempt. `result` changes only in that cycle and holds its value otherwise.
- R11: After reset, `busy`, `done`, `error` and `rd_req` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one coherent reading; ignored while busy |
| retry_mode | input | 1 | Policy, sampled at accepted start: 0 carry-resolve, 1 retry |
| rd_req | output | 1 | Narrow read request, held until served |
| rd_sel | output | 1 | Half select: 1 upper, 0 lower |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| busy | output | 1 | An attempt sequence is in progress |
| done | output | 1 | One-cycle strobe: a new result is available |
| result | output | 64 | Last coherent 64-bit reading |
| error | output | 1 | Retry limit exceeded; held until the next accepted start |

## Verification
The bench models the counter and the read responder. From the three samples it actually returned, it computes the expected word, and it predicts `done` and `error` to rise exactly two cycles after the valid cycle of the third read. It predicts `error` to clear one cycle after an accepted start. Every falling edge, it compares `done`, `error` and the held `result` against these predictions. It also compares the requested half against the expected position in the upper, lower, upper order. Counter presets just below a lower-half wrap, together with varied response latencies, place the carry before and after the lower read. A large counter step forces every retry attempt to disagree.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int HALF_W = 32;
    localparam int WORD_W = 2 * HALF_W;

    localparam logic SEL_LO = 1'b0;
    localparam logic SEL_HI = 1'b1;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HI_A = 3'd1,
        PH_LO   = 3'd2,
        PH_HI_B = 3'd3,
        PH_EVAL = 3'd4
    } phase_e;

    typedef enum logic {
        POL_CARRY = 1'b0,
        POL_RETRY = 1'b1
    } policy_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi_a;
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi_b;
    } snap_t;

    typedef struct packed {
        logic              agree;
        logic              usable;
        logic [WORD_W-1:0] word;
    } verdict_t;

    // Decide which upper sample belongs with the single lower sample.
    function automatic verdict_t judge(snap_t s, policy_e p);
        verdict_t          v;
        logic [HALF_W-1:0] upper;
        v.agree  = (s.hi_a == s.hi_b);
        v.usable = v.agree || (p == POL_CARRY);
        if (v.agree)
            upper = s.hi_a;
        else if (s.lo[HALF_W-1])
            upper = s.hi_a;   // lower sampled just before its wrap
        else
            upper = s.hi_b;   // lower sampled just after its wrap
        v.word = {upper, s.lo};
        return v;
    endfunction

endpackage

// File: rtl/scr_sequencer.sv
module scr_sequencer
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              retry_mode,
    input  logic              again,
    input  logic              rd_valid,
    input  logic [HALF_W-1:0] rd_data,
    output logic              rd_req,
    output logic              rd_sel,
    output logic              busy,
    output logic              start_ok,
    output logic              in_eval,
    output snap_t             snap,
    output policy_e           policy
);

    phase_e phase;

    assign rd_req   = (phase == PH_HI_A) || (phase == PH_LO) || (phase == PH_HI_B);
    assign rd_sel   = ((phase == PH_HI_A) || (phase == PH_HI_B)) ? SEL_HI : SEL_LO;
    assign busy     = (phase != PH_IDLE);
    assign start_ok = start && (phase == PH_IDLE);
    assign in_eval  = (phase == PH_EVAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            snap   <= '0;
            policy <= POL_CARRY;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_HI_A;
                        policy <= policy_e'(retry_mode);
                    end
                end
                PH_HI_A: begin
                    if (rd_valid) begin
                        snap.hi_a <= rd_data;
                        phase     <= PH_LO;
                    end
                end
                PH_LO: begin
                    if (rd_valid) begin
                        snap.lo <= rd_data;
                        phase   <= PH_HI_B;
                    end
                end
                PH_HI_B: begin
                    if (rd_valid) begin
                        snap.hi_b <= rd_data;
                        phase     <= PH_EVAL;
                    end
                end
                PH_EVAL: begin
                    phase <= again ? PH_HI_A : PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: a pending request keeps its half select until it is served
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_sel)));

    // R1: the second upper read is entered only from the lower read
    a_r1_order: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HI_B && $past(phase) != PH_HI_B) |-> ($past(phase) == PH_LO));

    // R6: a served lower read is never followed by another lower request
    a_r6_single_low: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid && rd_sel == SEL_LO) |=> !(rd_req && rd_sel == SEL_LO));

    // R9: a start during an unserved read leaves the read in place
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LO && start && !rd_valid) |=> (phase == PH_LO));

endmodule

// File: rtl/scr_resolver.sv
module scr_resolver
    import scr_pkg::*;
(
    input  snap_t             snap,
    input  policy_e           policy,
    output logic              agree,
    output logic              usable,
    output logic [WORD_W-1:0] word
);

    verdict_t v;

    always_comb begin
        v      = judge(snap, policy);
        agree  = v.agree;
        usable = v.usable;
        word   = v.word;
    end

    // R6: the assembled word always carries the single lower sample
    always_comb begin
        a_r6_low_kept: assert (word[HALF_W-1:0] == snap.lo);
    end

endmodule

// File: rtl/scr_retry_ctl.sv
module scr_retry_ctl #(
    parameter int RETRY_MAX = 8,
    localparam int CNT_W = $clog2(RETRY_MAX + 2)
) (
    input  logic clk,
    input  logic rst,
    input  logic start_ok,
    input  logic in_eval,
    input  logic usable,
    output logic again,
    output logic error
);

    logic [CNT_W-1:0] tries;
    logic             spent;
    logic             give_up;

    assign spent   = (tries == CNT_W'(RETRY_MAX));
    assign again   = in_eval && !usable && !spent;
    assign give_up = in_eval && !usable && spent;

    always_ff @(posedge clk) begin
        if (rst) begin
            tries <= '0;
            error <= 1'b0;
        end else if (start_ok) begin
            tries <= '0;
            error <= 1'b0;
        end else begin
            if (again)
                tries <= tries + 1'b1;
            if (give_up)
                error <= 1'b1;
        end
    end

    // R8: the retry count never passes its limit
    a_r8_tries_bound: assert property (@(posedge clk) disable iff (rst)
        tries <= CNT_W'(RETRY_MAX));

    // R8: giving up raises the error flag on the next cycle
    a_r8_error_raised: assert property (@(posedge clk) disable iff (rst)
        give_up |=> error);

endmodule

// File: rtl/split_counter_reader.sv
module split_counter_reader
    import scr_pkg::*;
#(
    parameter int RETRY_MAX = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              retry_mode,
    output logic              rd_req,
    output logic              rd_sel,
    input  logic              rd_valid,
    input  logic [HALF_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              error
);

    snap_t             snap;
    policy_e           policy;
    logic              start_ok;
    logic              in_eval;
    logic              again;
    logic              agree;
    logic              usable;
    logic [WORD_W-1:0] word;

    scr_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .retry_mode (retry_mode),
        .again      (again),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_req     (rd_req),
        .rd_sel     (rd_sel),
        .busy       (busy),
        .start_ok   (start_ok),
        .in_eval    (in_eval),
        .snap       (snap),
        .policy     (policy)
    );

    scr_resolver u_res (
        .snap   (snap),
        .policy (policy),
        .agree  (agree),
        .usable (usable),
        .word   (word)
    );

    scr_retry_ctl #(.RETRY_MAX(RETRY_MAX)) u_retry (
        .clk      (clk),
        .rst      (rst),
        .start_ok (start_ok),
        .in_eval  (in_eval),
        .usable   (usable),
        .again    (again),
        .error    (error)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (in_eval && usable) begin
                result <= word;
                done   <= 1'b1;
            end
        end
    end

    // R10: done never lasts beyond one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: the result register moves only together with done
    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    // R8: an error outcome never comes with a done strobe
    a_r8_no_done_on_error: assert property (@(posedge clk) disable iff (rst)
        error |-> !done);

    // R7: a discarded attempt restarts with an upper-half request
    a_r7_restart_upper: assert property (@(posedge clk) disable iff (rst)
        again |=> (rd_req && rd_sel == SEL_HI));

    // R3: matching upper samples are accepted under either policy
    a_r3_agree_accepted: assert property (@(posedge clk) disable iff (rst)
        (in_eval && agree) |=> done);

endmodule

// File: tb/split_counter_reader_bench.sv
module split_counter_reader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 8;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        retry_mode = 1'b0;
    logic        rd_req;
    logic        rd_sel;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy;
    logic        done;
    logic [63:0] result;
    logic        error;

    split_counter_reader #(.RETRY_MAX(LIMIT)) u_split_counter_reader (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .retry_mode (retry_mode),
        .rd_req     (rd_req),
        .rd_sel     (rd_sel),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .busy       (busy),
        .done       (done),
        .result     (result),
        .error      (error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running counter model
    logic [63:0] cnt  = '0;
    logic [63:0] step = 64'd1;
    always @(posedge clk) cnt <= cnt + step;

    int checks = 0;
    int errors = 0;
    int ncyc   = 0;

    // Reference model state
    int          seq_idx   = 0;
    logic [31:0] samp [3];
    int          tries     = 0;
    bit          pol_retry = 0;
    int          done_cyc  = -1;
    int          eset_cyc  = -1;
    int          eclr_cyc  = -1;
    bit          exp_err   = 0;
    logic [63:0] exp_word  = '0;
    logic [63:0] held      = '0;
    string       exp_tag   = "R3";
    int          wait_left = 0;
    int          lat_mode  = 0;
    int          resp_n    = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h (cycle %0d)", req, act, exp, ncyc);
        end
    endtask

    function automatic int next_lat();
        if (lat_mode == 0) return 0;
        return (resp_n * 2 + 1) % 4;
    endfunction

    // One negedge: compare outputs against the model, then serve reads
    task automatic tick();
        bit exp_done;
        @(negedge clk);
        ncyc++;
        if (ncyc > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", ncyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (rst) return;
        if (ncyc == eclr_cyc) exp_err = 0;
        if (ncyc == eset_cyc) exp_err = 1;
        exp_done = (ncyc == done_cyc);
        if (exp_done) held = exp_word;
        chk(done == exp_done, "R10 done timing", 64'(done), 64'(exp_done));
        chk(result == held, exp_done ? exp_tag : "R10 result hold", result, held);
        chk(error == exp_err, "R8 error flag", 64'(error), 64'(exp_err));
        rd_valid = 1'b0;
        if (rd_req) begin
            chk(rd_sel == (seq_idx != 1), "R1 read order", 64'(rd_sel), 64'(seq_idx != 1));
            if (wait_left > 0) begin
                wait_left--;
            end else begin
                rd_valid = 1'b1;
                rd_data  = rd_sel ? cnt[63:32] : cnt[31:0];
                samp[seq_idx] = rd_data;
                seq_idx++;
                resp_n++;
                wait_left = next_lat();
                if (seq_idx == 3) begin
                    seq_idx = 0;
                    if (samp[0] == samp[2]) begin
                        done_cyc = ncyc + 2;
                        exp_word = {samp[0], samp[1]};
                        exp_tag  = pol_retry ? "R7 matched retry" : "R3 equal uppers";
                    end else if (!pol_retry) begin
                        done_cyc = ncyc + 2;
                        if (samp[1][31]) begin
                            exp_word = {samp[0], samp[1]};
                            exp_tag  = "R4 first upper";
                        end else begin
                            exp_word = {samp[2], samp[1]};
                            exp_tag  = "R5 second upper";
                        end
                    end else if (tries == LIMIT) begin
                        eset_cyc = ncyc + 2;
                    end else begin
                        tries++;
                    end
                end
            end
        end
    endtask

    task automatic launch(input bit mode, input logic [63:0] preset, input logic [63:0] stp, input int lm);
        tick();
        chk(busy == 1'b0, "R9 idle before start", 64'(busy), 64'd0);
        cnt        = preset;
        step       = stp;
        lat_mode   = lm;
        wait_left  = next_lat();
        retry_mode = mode;
        pol_retry  = mode;
        tries      = 0;
        seq_idx    = 0;
        eclr_cyc   = ncyc + 1;
        start      = 1'b1;
        tick();
        start = 1'b0;
        chk(busy == 1'b1, "R9 start accepted", 64'(busy), 64'd1);
    endtask

    task automatic finish_txn(input bit poke);
        int guard = 0;
        while (busy && guard < 2000) begin
            if (poke && guard == 1) begin
                start = 1'b1;   // R9: must be ignored while busy
                tick();
                start = 1'b0;
            end else begin
                tick();
            end
            guard++;
        end
        chk(busy == 1'b0, "R10 sequence ends", 64'(busy), 64'd0);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        // R11 reset values
        chk(busy == 0 && done == 0 && error == 0 && rd_req == 0, "R11 reset controls",
            {60'd0, busy, done, error, rd_req}, 64'd0);
        chk(result == 64'd0, "R11 reset result", result, 64'd0);
        rst = 1'b0;
        tick();

        // R3: no carry during the attempt
        launch(0, 64'h0000_0012_0000_0100, 64'd1, 0); finish_txn(0);
        // R4: wrap between lower and second upper read
        launch(0, 64'h0000_0005_FFFF_FFFD, 64'd1, 0); finish_txn(0);
        // R5: wrap between first upper and lower read
        launch(0, 64'h0000_0005_FFFF_FFFE, 64'd1, 0); finish_txn(0);
        // R2: latency on every read, carry-resolve with wraps
        launch(0, 64'h0000_00A0_FFFF_FFFB, 64'd1, 1); finish_txn(0);
        launch(0, 64'h0000_00A0_FFFF_FFF8, 64'd1, 1); finish_txn(0);
        // R7: one discarded attempt, then a matching one
        launch(1, 64'h0000_0005_FFFF_FFFD, 64'd1, 0); finish_txn(0);
        // R8: every attempt disagrees, error after the limit
        launch(1, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000, 0); finish_txn(0);
        chk(error == 1'b1, "R8 error held", 64'(error), 64'd1);
        tick();
        // R8: next accepted start clears the error
        launch(0, 64'h0000_0033_0000_0010, 64'd1, 0); finish_txn(0);
        chk(error == 1'b0, "R8 error cleared", 64'(error), 64'd0);
        // R9: start pulse in the middle of a sequence
        launch(0, 64'h0000_0044_7FFF_0000, 64'd1, 1); finish_txn(1);
        // Mixed patterns
        for (int k = 0; k < 24; k++) begin
            launch(k[0], {24'd0, 8'(k), 32'hFFFF_FFF0 + 32'(k % 12)}, 64'(1 + k % 3), k % 2);
            finish_txn(k % 5 == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule